// File: doc/BRIEF.md
# Programmable Baud Rate Clock Generator

This block turns a fixed 4.9152 MHz reference clock into sampling enables for a serial transmitter and receiver. A 4-bit rate code selects one of sixteen fixed divide ratios. The divider output runs at sixteen times the chosen baud rate, from 50 baud for the slowest code to 19200 baud for the fastest. A second divide by sixteen on each path gives a one-per-bit enable.

A 2-bit source field decides, for each path on its own, whether its 16X enable comes from the internal divider or from an external clock input. The external inputs are asynchronous. They are synchronized, and every rising edge becomes one reference-cycle pulse. When neither path uses the divider, the rate code has no effect on any output.

All outputs are single-cycle, active-high enables in the reference clock domain. Downstream logic uses them as clock enables and never as clocks.

Top module: `baudgen_top`

## Requirements
- R1: With a path on the internal source and the rate code held, its 16X pulses repeat every D reference cycles. D depends on the code: 0->6144, 1->4096, 2->2793, 3->2284, 4->2048, 5->1536, 6->1024, 7->512, 8->292, 9->256, 10->171, 11->154, 12->128, 13->64, 14->32, 15->16.
- R2: On each path the bit pulse is high in exactly the cycle of every 16th 16X pulse of that path. The first bit pulse after reset comes with the 16th 16X pulse.
- R3: Every 16X pulse and every bit pulse lasts exactly one reference cycle.
- R4: The source field works per path. Bit 0 set means the transmit path uses the internal divider, and bit 0 clear means it uses extTxClk. Bit 1 does the same for the receive path and extRxClk. With the field at 00, the rate code has no effect, and with the external inputs idle no pulse appears.
- R5: On a path using its external input, each rising edge of that input gives exactly one 16X pulse. The pulse is high in the cycle after the third reference rising edge that follows the input edge.
- R6: A change of the rate code restarts the divider at the first reference edge that sees the new code. No internal pulse follows that edge. The next internal pulse follows the edge D_new cycles later.
- R7: Reset is synchronous and active high. While it is held, all four outputs stay low. After release, the first internal 16X pulse follows the D-th rising edge, and bit counters restart from zero.
- R8: When both paths use the internal source, their 16X pulses come in the same cycles, because one shared divider drives them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.9152 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rateSel | input | 4 | Rate code selecting the divide ratio |
| clkSrc | input | 2 | Source field: bit 0 transmit internal, bit 1 receive internal |
| extTxClk | input | 1 | External 16X transmit clock, asynchronous |
| extRxClk | input | 1 | External 16X receive clock, asynchronous |
| txTick16 | output | 1 | Transmit 16X enable pulse |
| txTickBit | output | 1 | Transmit bit-rate enable pulse |
| rxTick16 | output | 1 | Receive 16X enable pulse |
| rxTickBit | output | 1 | Receive bit-rate enable pulse |

## Verification
The divider is tried with all sixteen rate codes straight after reset. Each code is checked for both the delay to the first pulse and the spacing between pulses, so a wrong table entry is told apart from an off-by-one reload. The bit divide is checked against both the pulse count and the absolute cycle count, and a mid-run code change separates a proper restart from a counter that just keeps counting down. The source-field patterns 00, 01 and 10 are driven with the external inputs idle and then toggled. This shows that each field bit steers only its own path and that, in external mode, the rate code leaves the outputs untouched.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  localparam int DIV_W     = 13;
  localparam int NUM_PATHS = 2;
  localparam int PATH_TX   = 0;
  localparam int PATH_RX   = 1;

  typedef struct packed {
    logic                 reload;
    logic [NUM_PATHS-1:0] useInt;
    logic [NUM_PATHS-1:0] extRise;
  } bg_strobe_t;

  function automatic logic [DIV_W-1:0] rateDivisor(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = DIV_W'(6144);
      4'd1:    d = DIV_W'(4096);
      4'd2:    d = DIV_W'(2793);
      4'd3:    d = DIV_W'(2284);
      4'd4:    d = DIV_W'(2048);
      4'd5:    d = DIV_W'(1536);
      4'd6:    d = DIV_W'(1024);
      4'd7:    d = DIV_W'(512);
      4'd8:    d = DIV_W'(292);
      4'd9:    d = DIV_W'(256);
      4'd10:   d = DIV_W'(171);
      4'd11:   d = DIV_W'(154);
      4'd12:   d = DIV_W'(128);
      4'd13:   d = DIV_W'(64);
      4'd14:   d = DIV_W'(32);
      default: d = DIV_W'(16);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/baudgen_ctrl.sv
module baudgen_ctrl
  import baudgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           rateSel,
  input  logic [1:0]           clkSrc,
  input  logic [NUM_PATHS-1:0] extClk,
  output bg_strobe_t           strobe
);

  logic [3:0]           codeQ;
  logic [NUM_PATHS-1:0] riseVec;

  // last code seen; a mismatch requests a divider restart
  always_ff @(posedge clk) codeQ <= rateSel;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], extClk[p]};
        prevQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign riseVec[p] = syncQ[SYNC_STAGES-1] & ~prevQ;
  end

  always_comb begin
    strobe.reload  = (rateSel != codeQ);
    strobe.useInt  = clkSrc;
    strobe.extRise = riseVec;
  end

endmodule

// File: rtl/baudgen_datapath.sv
module baudgen_datapath
  import baudgen_pkg::*;
#(
  parameter int BIT_DIV = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           rateSel,
  input  bg_strobe_t           strobe,
  output logic [NUM_PATHS-1:0] tick16,
  output logic [NUM_PATHS-1:0] tickBit
);

  localparam int BIT_W = $clog2(BIT_DIV);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] divCnt;
  logic             wrap;

  assign divisor = rateDivisor(rateSel);
  assign wrap    = (divCnt == '0) && !strobe.reload;

  // shared down-counter for every internally clocked path
  always_ff @(posedge clk) begin
    if (rst || strobe.reload || divCnt == '0) begin
      divCnt <= divisor - DIV_W'(1);
    end else begin
      divCnt <= divCnt - DIV_W'(1);
    end
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic             tickQ;
    logic [BIT_W-1:0] bitCnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        tickQ <= 1'b0;
      end else begin
        tickQ <= strobe.useInt[p] ? wrap : strobe.extRise[p];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        bitCnt <= '0;
      end else if (tickQ) begin
        bitCnt <= (bitCnt == BIT_W'(BIT_DIV-1)) ? '0 : bitCnt + BIT_W'(1);
      end
    end

    assign tick16[p]  = tickQ;
    assign tickBit[p] = tickQ && (bitCnt == BIT_W'(BIT_DIV-1));
  end

endmodule

// File: rtl/baudgen_top.sv
module baudgen_top
  import baudgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rateSel,
  input  logic [1:0] clkSrc,
  input  logic       extTxClk,
  input  logic       extRxClk,
  output logic       txTick16,
  output logic       txTickBit,
  output logic       rxTick16,
  output logic       rxTickBit
);

  bg_strobe_t           strobe;
  logic [NUM_PATHS-1:0] tick16;
  logic [NUM_PATHS-1:0] tickBit;
  logic [NUM_PATHS-1:0] extClk;

  assign extClk[PATH_TX] = extTxClk;
  assign extClk[PATH_RX] = extRxClk;

  baudgen_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .rateSel(rateSel),
    .clkSrc (clkSrc),
    .extClk (extClk),
    .strobe (strobe)
  );

  baudgen_datapath #(.BIT_DIV(16)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .rateSel(rateSel),
    .strobe (strobe),
    .tick16 (tick16),
    .tickBit(tickBit)
  );

  assign txTick16  = tick16[PATH_TX];
  assign txTickBit = tickBit[PATH_TX];
  assign rxTick16  = tick16[PATH_RX];
  assign rxTickBit = tickBit[PATH_RX];

endmodule

// File: rtl/baudgen_checker.sv
module baudgen_checker
  import baudgen_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] rateSel,
  input logic [1:0] clkSrc,
  input logic       txTick16,
  input logic       txTickBit,
  input logic       rxTick16,
  input logic       rxTickBit
);

  logic        rstQ;
  logic [3:0]  codeSeen;
  logic        srcSeen;
  logic        txArmed;
  logic [15:0] txGap;
  logic [4:0]  txCnt;
  logic [4:0]  rxCnt;

  always_ff @(posedge clk) begin
    rstQ     <= rst;
    codeSeen <= rateSel;
    srcSeen  <= clkSrc[0];
    if (rst) begin
      txArmed <= 1'b0;
      txGap   <= '0;
      txCnt   <= '0;
      rxCnt   <= '0;
    end else begin
      txGap <= txTick16 ? 16'd0 : txGap + 16'd1;
      if (rateSel != codeSeen || clkSrc[0] != srcSeen || !clkSrc[0]) txArmed <= 1'b0;
      else if (txTick16) txArmed <= 1'b1;
      if (txTick16) txCnt <= txTickBit ? 5'd0 : txCnt + 5'd1;
      if (rxTick16) rxCnt <= rxTickBit ? 5'd0 : rxCnt + 5'd1;
    end
  end

  always @(negedge clk) begin
    if (rstQ === 1'b1) begin
      assert_quiet_in_reset_R7: assert (!(txTick16 || txTickBit || rxTick16 || rxTickBit))
        else $error("outputs active during reset");
    end
  end

  assert_tx_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (txTick16 && txArmed && clkSrc[0] && rateSel == codeSeen)
      |-> (txGap == {3'b0, rateDivisor(rateSel)} - 16'd1));

  assert_tx_bit_ratio_R2: assert property (@(posedge clk) disable iff (rst)
    txTickBit |-> (txTick16 && txCnt == 5'd15));

  assert_rx_bit_ratio_R2: assert property (@(posedge clk) disable iff (rst)
    rxTickBit |-> (rxTick16 && rxCnt == 5'd15));

  assert_tx_single_R3: assert property (@(posedge clk) disable iff (rst)
    txTick16 |=> !txTick16);

  assert_rx_single_R3: assert property (@(posedge clk) disable iff (rst)
    rxTick16 |=> !rxTick16);

  assert_reload_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (clkSrc[0] && rateSel != $past(rateSel)) |=> !txTick16);

  assert_shared_divider_R8: assert property (@(posedge clk) disable iff (rst)
    (clkSrc == 2'b11 && $past(clkSrc) == 2'b11) |-> (txTick16 == rxTick16));

endmodule

bind baudgen_top baudgen_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .rateSel  (rateSel),
  .clkSrc   (clkSrc),
  .txTick16 (txTick16),
  .txTickBit(txTickBit),
  .rxTick16 (rxTick16),
  .rxTickBit(rxTickBit)
);

// File: tb/sim_baudgen_top.sv
`timescale 1ns/1ps
module sim_baudgen_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rateSel = 4'd15;
  logic [1:0] clkSrc = 2'b11;
  logic       extTxClk = 1'b0;
  logic       extRxClk = 1'b0;
  logic       txTick16, txTickBit, rxTick16, rxTickBit;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  baudgen_top u0 (
    .clk(clk), .rst(rst), .rateSel(rateSel), .clkSrc(clkSrc),
    .extTxClk(extTxClk), .extRxClk(extRxClk),
    .txTick16(txTick16), .txTickBit(txTickBit),
    .rxTick16(rxTick16), .rxTickBit(rxTickBit)
  );

  // rate code -> expected divisor
  localparam int unsigned VEC[16][2] = '{
    '{0, 6144}, '{1, 4096}, '{2, 2793}, '{3, 2284},
    '{4, 2048}, '{5, 1536}, '{6, 1024}, '{7, 512},
    '{8, 292},  '{9, 256},  '{10, 171}, '{11, 154},
    '{12, 128}, '{13, 64},  '{14, 32},  '{15, 16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input int cyc);
    @(negedge clk);
    rst = 1'b1;
    repeat (cyc) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic waitTx(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!txTick16 && n < 20000);
  endtask

  task automatic countTicks(input int cyc, output int tx, output int rx);
    tx = 0; rx = 0;
    repeat (cyc) begin
      @(posedge clk); #1;
      if (txTick16) tx++;
      if (rxTick16) rx++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, tx, rx, txb, c16, cyc;

    // R7: quiet while reset is held, even with external edges
    rst = 1'b1; clkSrc = 2'b11; rateSel = 4'd15;
    tx = 0; rx = 0; txb = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); extTxClk = (i % 6) < 3; extRxClk = extTxClk;
      @(posedge clk); #1;
      if (txTick16 || rxTick16) tx++;
      if (txTickBit || rxTickBit) txb++;
    end
    extTxClk = 1'b0; extRxClk = 1'b0;
    check(tx == 0, "R7", tx, 0, "16X pulses during reset");
    check(txb == 0, "R7", txb, 0, "bit pulses during reset");

    // table walk: R7 first-pulse delay, R8 shared, R3 width, R1 spacing
    foreach (VEC[k]) begin
      @(negedge clk);
      rateSel = 4'(VEC[k][0]); clkSrc = 2'b11;
      doReset(2);
      waitTx(n);
      check(n == int'(VEC[k][1]), "R7", n, int'(VEC[k][1]), "first pulse after reset");
      check(rxTick16 == 1'b1, "R8", int'(rxTick16), 1, "rx with tx");
      @(posedge clk); #1;
      check(txTick16 == 1'b0, "R3", int'(txTick16), 0, "pulse width");
      waitTx(n);
      check(n == int'(VEC[k][1]) - 1, "R1", n, int'(VEC[k][1]) - 1, "spacing");
    end

    // R2: bit pulse with 16th 16X pulse, 256 cycles at code 15
    @(negedge clk); rateSel = 4'd15; clkSrc = 2'b11;
    doReset(2);
    c16 = 0; cyc = 0;
    do begin
      @(posedge clk); #1; cyc++;
      if (txTick16) c16++;
    end while (!txTickBit && cyc < 1000);
    check(c16 == 16, "R2", c16, 16, "16X pulses to first bit pulse");
    check(cyc == 256, "R2", cyc, 256, "cycles to first bit pulse");
    check(rxTickBit == 1'b1, "R2", int'(rxTickBit), 1, "rx bit pulse");
    @(posedge clk); #1;
    check(txTickBit == 1'b0, "R3", int'(txTickBit), 0, "bit pulse width");
    cyc = 1;
    do begin
      @(posedge clk); #1; cyc++;
    end while (!txTickBit && cyc < 1000);
    check(cyc == 256, "R2", cyc, 256, "bit pulse spacing");

    // R6: code change restarts the divider
    @(negedge clk); rateSel = 4'd13;
    doReset(2);
    waitTx(n);
    check(n == 64, "R1", n, 64, "code 13 first pulse");
    repeat (10) @(negedge clk);
    rateSel = 4'd15;
    waitTx(n);
    check(n == 17, "R6", n, 17, "pulse after code change");
    waitTx(n);
    check(n == 16, "R6", n, 16, "spacing after code change");

    // R4: source 00 ignores the rate code
    @(negedge clk); clkSrc = 2'b00; rateSel = 4'd15;
    doReset(2);
    countTicks(300, tx, rx);
    check(tx == 0, "R4", tx, 0, "tx pulses with source 00");
    check(rx == 0, "R4", rx, 0, "rx pulses with source 00");

    // R5: external edge latency
    @(negedge clk); extTxClk = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!txTick16 && n < 50);
    check(n == 3, "R5", n, 3, "tx external edge latency");
    check(rxTick16 == 1'b0, "R4", int'(rxTick16), 0, "rx stays quiet");
    @(negedge clk); extTxClk = 1'b0;
    repeat (4) @(negedge clk);
    extRxClk = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!rxTick16 && n < 50);
    check(n == 3, "R5", n, 3, "rx external edge latency");
    @(negedge clk); extRxClk = 1'b0;
    repeat (6) @(negedge clk);

    // R5/R2: 20 external rises -> 20 pulses, one bit pulse
    doReset(2);
    tx = 0; txb = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk); extTxClk = (i % 8) < 4;
      @(posedge clk); #1;
      if (txTick16) tx++;
      if (txTickBit) txb++;
    end
    @(negedge clk); extTxClk = 1'b0;
    check(tx == 20, "R5", tx, 20, "pulses per external rise");
    check(txb == 1, "R2", txb, 1, "bit pulses from external clock");

    // R4: per-path source bits
    @(negedge clk); clkSrc = 2'b01; rateSel = 4'd15;
    doReset(2);
    countTicks(200, tx, rx);
    check(tx == 12, "R4", tx, 12, "source 01 tx internal");
    check(rx == 0, "R4", rx, 0, "source 01 rx external idle");
    @(negedge clk); clkSrc = 2'b10;
    doReset(2);
    countTicks(200, tx, rx);
    check(tx == 0, "R4", tx, 0, "source 10 tx external idle");
    check(rx == 12, "R4", rx, 12, "source 10 rx internal");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule